// File: doc/BRIEF.md
# AXI4 Data-Beat Delay Bridge

This bridge sits between an AXI4 master, or a register slice, and a slave that is left unchanged. It holds back every data beat on the write data and read data channels for a fixed number of clock cycles, set by a parameter with a default of 15. The bridge only gates the valid/ready handshake. Payload fields pass through untouched, and the write address, read address and write response channels are wired straight across.

Each beat has its own wait window, so every word of a burst is delayed. A lone single-beat transfer gets the same delay as a burst beat.

On the write side, the wait window opens when the master offers a beat. On the read side, it opens when the slave offers one. While the window runs, the bridge shows no valid toward the far side and no ready toward the near side, so neither side sees a handshake. When the window closes, the original handshake goes through unchanged. After a completed handshake, the next beat's window begins in the following cycle.

Top module: `axi_beat_delay`

## Requirements
- R1: With `WAIT_CYC` = N and a slave that holds `m_wready` high, a write beat whose `s_wvalid` first rises in cycle t completes its handshake (`s_wvalid` and `s_wready` both 1) in cycle t+N, and no earlier.
- R2: During the wait, `m_wvalid` and `s_wready` are both 0. Every handshake on the master side of the write data channel occurs in the same cycle as a handshake on the slave side.
- R3: In a burst, every beat is delayed on its own. The next beat's N-cycle window starts in the cycle after the previous handshake, so with ready partners consecutive handshakes are N+1 cycles apart.
- R4: A single-beat write, or a single-beat read, is delayed by exactly N cycles, the same as a burst beat.
- R5: A read beat whose `m_rvalid` first rises in cycle t is hidden from the master until then. `s_rvalid` and `m_rready` stay 0 until cycle t+N. With `s_rready` held high, the handshake happens in cycle t+N.
- R6: `m_wdata`, `m_wstrb` and `m_wlast` always equal `s_wdata`, `s_wstrb` and `s_wlast`. `s_rdata`, `s_rresp` and `s_rlast` always equal `m_rdata`, `m_rresp` and `m_rlast`.
- R7: The write address, read address and write response channels pass through combinationally in the same cycle: addr, len, valid and ready on both address channels, and bresp, valid and ready on the response channel.
- R8: Once the window has elapsed, a beat stays offered until its handshake. `m_wvalid`, or `s_rvalid`, that is high without the matching ready stays high in the next cycle.
- R9: Synchronous active-high `rst` clears both wait counters. In the cycle after reset is sampled, `m_wvalid`, `s_wready`, `s_rvalid` and `m_rready` are 0, even if the inputs request a transfer.
- R10: Once the window has elapsed, a beat that meets backpressure from the slave (write) or from the master (read) completes in the first cycle that ready is high, with no second wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address from master |
| s_awlen | input | LEN_W | Write burst length from master |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| m_awaddr | output | ADDR_W | Write address to slave |
| m_awlen | output | LEN_W | Write burst length to slave |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Write address ready from slave |
| s_wdata | input | DATA_W | Write data from master |
| s_wstrb | input | DATA_W/8 | Write strobes from master |
| s_wlast | input | 1 | Last write beat from master |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Gated write data ready to master |
| m_wdata | output | DATA_W | Write data to slave |
| m_wstrb | output | DATA_W/8 | Write strobes to slave |
| m_wlast | output | 1 | Last write beat to slave |
| m_wvalid | output | 1 | Gated write data valid to slave |
| m_wready | input | 1 | Write data ready from slave |
| m_bresp | input | 2 | Write response from slave |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Write response ready to slave |
| s_bresp | output | 2 | Write response to master |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_araddr | input | ADDR_W | Read address from master |
| s_arlen | input | LEN_W | Read burst length from master |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| m_araddr | output | ADDR_W | Read address to slave |
| m_arlen | output | LEN_W | Read burst length to slave |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Read address ready from slave |
| m_rdata | input | DATA_W | Read data from slave |
| m_rresp | input | 2 | Read response from slave |
| m_rlast | input | 1 | Last read beat from slave |
| m_rvalid | input | 1 | Read data valid from slave |
| m_rready | output | 1 | Gated read data ready to slave |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response to master |
| s_rlast | output | 1 | Last read beat to master |
| s_rvalid | output | 1 | Gated read data valid to master |
| s_rready | input | 1 | Read data ready from master |

## Verification
The bench drives several transfer shapes:
- A lone single-beat write and a lone single-beat read, each with an always-ready partner. These show whether the delay depends on burst context.
- Four-beat bursts on both data channels. These separate a per-beat window from a window that only covers the first beat.
- Back-to-back single writes with a one-cycle gap between them. These show whether the window restarts after each beat.
- Concurrent bursts against a toggling slave write ready and a toggling master read ready. These separate a beat that finishes as soon as ready returns from one that waits a second time.

A behavioural cycle model of every gated output is compared on every clock. The address and response channels carry changing values throughout, so a broken pass-through shows up.

// File: rtl/axi_beat_delay.sv
module axi_beat_delay #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int WAIT_CYC = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [LEN_W-1:0]    s_awlen,
  input  logic                s_awvalid,
  output logic                s_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic                m_awvalid,
  input  logic                m_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [LEN_W-1:0]    s_arlen,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [LEN_W-1:0]    m_arlen,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast,
  output logic                s_rvalid,
  input  logic                s_rready
);

  localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WAIT_CYC);

  logic [CNT_W-1:0] w_cnt, r_cnt;
  logic             w_done, r_done, w_hs, r_hs;

  // address and response channels: straight wires
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign m_awvalid = s_awvalid;
  assign s_awready = m_awready;
  assign m_araddr  = s_araddr;
  assign m_arlen   = s_arlen;
  assign m_arvalid = s_arvalid;
  assign s_arready = m_arready;
  assign s_bresp   = m_bresp;
  assign s_bvalid  = m_bvalid;
  assign m_bready  = s_bready;

  // write data: master offers, slave sees it only after the window
  assign w_done   = (w_cnt == CNT_END);
  assign m_wvalid = s_wvalid & w_done;
  assign s_wready = m_wready & w_done;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = s_wlast;
  assign w_hs     = m_wvalid & m_wready;

  always_ff @(posedge clk) begin
    if (rst)                       w_cnt <= '0;
    else if (w_hs)                 w_cnt <= '0;
    else if (s_wvalid && !w_done)  w_cnt <= w_cnt + 1'b1;
  end

  // read data: slave offers, master sees it only after the window
  assign r_done   = (r_cnt == CNT_END);
  assign s_rvalid = m_rvalid & r_done;
  assign m_rready = s_rready & r_done;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = m_rlast;
  assign r_hs     = s_rvalid & s_rready;

  always_ff @(posedge clk) begin
    if (rst)                       r_cnt <= '0;
    else if (r_hs)                 r_cnt <= '0;
    else if (m_rvalid && !r_done)  r_cnt <= r_cnt + 1'b1;
  end

  generate
    if (WAIT_CYC > 0) begin : g_chk
      AST_W_FIRST_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        $rose(s_wvalid) |-> !m_wvalid && !s_wready);                     // R1
      AST_W_HS_PAIRED: assert property (@(posedge clk) disable iff (rst)
        (s_wvalid && s_wready) |-> (m_wvalid && m_wready));              // R2
      AST_R_FIRST_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        $rose(m_rvalid) |-> !s_rvalid && !m_rready);                     // R5
      AST_W_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && !m_wready) |=> m_wvalid);                           // R8
      AST_R_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));     // R8
      AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!m_wvalid && !s_wready && !s_rvalid && !m_rready));     // R9
    end
  endgenerate

endmodule

// File: tb/axi_beat_delay_bench.sv
`timescale 1ns/1ps
module axi_beat_delay_bench;
  localparam int AW = 32, DW = 32, LW = 8, N = 15;

  logic clk = 0, rst = 1;
  logic [AW-1:0] s_awaddr = 0, m_awaddr, s_araddr = 0, m_araddr;
  logic [LW-1:0] s_awlen = 0, m_awlen, s_arlen = 0, m_arlen;
  logic s_awvalid = 0, s_awready, m_awvalid, m_awready = 0;
  logic s_arvalid = 0, s_arready, m_arvalid, m_arready = 0;
  logic [DW-1:0] s_wdata = 0, m_wdata, m_rdata = 0, s_rdata;
  logic [DW/8-1:0] s_wstrb = 0, m_wstrb;
  logic s_wlast = 0, m_wlast, s_wvalid = 1, s_wready, m_wvalid, m_wready = 1;
  logic [1:0] m_bresp = 0, s_bresp, m_rresp = 0, s_rresp;
  logic m_bvalid = 0, m_bready, s_bvalid, s_bready = 0;
  logic m_rlast = 0, s_rlast, m_rvalid = 1, m_rready, s_rvalid, s_rready = 1;

  int checks = 0, errors = 0;
  int wmode = 0, rmode = 0;
  int wa = 0, ra = 0;
  bit prev_wv_stall = 0, prev_rv_stall = 0;
  logic [3:0] tick = 0;

  always #2 clk = ~clk;

  axi_beat_delay #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .WAIT_CYC(N)) u_axi_beat_delay (.*);

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // partner readiness and pass-through traffic
  always @(posedge clk) begin
    #1;
    tick = tick + 1'b1;
    m_wready = (wmode == 0) || tick[0];
    s_rready = (rmode == 0) || tick[1];
    s_awaddr = $urandom; s_awlen = LW'($urandom); s_awvalid = tick[2];
    m_awready = tick[0]; s_araddr = $urandom; s_arlen = LW'($urandom);
    s_arvalid = tick[1]; m_arready = tick[3]; m_bresp = 2'($urandom);
    m_bvalid = tick[2]; s_bready = tick[1];
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    bit ew_v, ew_r, er_v, er_r;
    ew_v = !rst && s_wvalid && (wa >= N);
    ew_r = !rst && m_wready && (wa >= N);
    er_v = !rst && m_rvalid && (ra >= N);
    er_r = !rst && s_rready && (ra >= N);
    chk(m_wvalid == ew_v, "R2", "m_wvalid", m_wvalid, ew_v);
    chk(s_wready == ew_r, "R1", "s_wready", s_wready, ew_r);
    chk(s_rvalid == er_v, "R5", "s_rvalid", s_rvalid, er_v);
    chk(m_rready == er_r, "R5", "m_rready", m_rready, er_r);
    chk(m_wdata == s_wdata && m_wstrb == s_wstrb && m_wlast == s_wlast, "R6", "w payload", m_wdata, s_wdata);
    chk(s_rdata == m_rdata && s_rresp == m_rresp && s_rlast == m_rlast, "R6", "r payload", s_rdata, m_rdata);
    chk(m_awaddr == s_awaddr && m_awlen == s_awlen && m_awvalid == s_awvalid && s_awready == m_awready,
        "R7", "aw pass", m_awaddr, s_awaddr);
    chk(m_araddr == s_araddr && m_arlen == s_arlen && m_arvalid == s_arvalid && s_arready == m_arready,
        "R7", "ar pass", m_araddr, s_araddr);
    chk(s_bresp == m_bresp && s_bvalid == m_bvalid && m_bready == s_bready, "R7", "b pass", s_bresp, m_bresp);
    if (!rst) begin
      if (prev_wv_stall) chk(m_wvalid, "R8", "m_wvalid held", m_wvalid, 1);
      if (prev_rv_stall) chk(s_rvalid, "R8", "s_rvalid held", s_rvalid, 1);
    end
    prev_wv_stall = !rst && ew_v && !m_wready;
    prev_rv_stall = !rst && er_v && !s_rready;
    if (rst) wa = 0;
    else if (ew_v && m_wready) wa = 0;
    else if (s_wvalid && wa < N) wa++;
    if (rst) ra = 0;
    else if (er_v && s_rready) ra = 0;
    else if (m_rvalid && ra < N) ra++;
  end

  task automatic do_write(input int n, input bit exact, input string tag);
    for (int b = 0; b < n; b++) begin
      int cyc;
      cyc = 0;
      @(posedge clk); #1;
      s_wvalid = 1; s_wdata = $urandom; s_wstrb = 4'($urandom); s_wlast = (b == n - 1);
      do begin @(negedge clk); cyc++; end while (!s_wready);
      if (exact) chk(cyc - 1 == N, tag, "write beat wait", cyc - 1, N);
      else chk(cyc - 1 >= N, "R10", "write beat wait min", cyc - 1, N);
    end
    @(posedge clk); #1; s_wvalid = 0; s_wlast = 0;
  endtask

  task automatic do_read(input int n, input bit exact, input string tag);
    for (int b = 0; b < n; b++) begin
      int cyc;
      cyc = 0;
      @(posedge clk); #1;
      m_rvalid = 1; m_rdata = $urandom; m_rresp = 2'($urandom); m_rlast = (b == n - 1);
      do begin @(negedge clk); cyc++; end while (!m_rready);
      if (exact) chk(cyc - 1 == N, tag, "read beat wait", cyc - 1, N);
      else chk(cyc - 1 >= N, "R10", "read beat wait min", cyc - 1, N);
    end
    @(posedge clk); #1; m_rvalid = 0; m_rlast = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_wvalid && !s_wready && !s_rvalid && !m_rready, "R9", "gated outputs in reset",
        {m_wvalid, s_wready, s_rvalid, m_rready}, 0);
    @(posedge clk); #1;
    rst = 0; s_wvalid = 0; m_rvalid = 0;
    repeat (2) @(posedge clk);
    do_write(1, 1, "R4");
    do_read(1, 1, "R4");
    do_write(4, 1, "R3");
    do_read(4, 1, "R5");
    do_write(1, 1, "R1");
    do_write(1, 1, "R1");
    wmode = 1; rmode = 1;
    fork
      do_write(5, 0, "R10");
      do_read(5, 0, "R10");
    join
    wmode = 0; rmode = 0;
    fork
      do_write(3, 1, "R3");
      do_read(3, 1, "R3");
    join
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule